// File: doc/BRIEF.md
# Cyclic Pass-Window Phase Selector

After a sampling-phase sweep, a receive-timing tuner has one pass/fail result for each of its 16 candidate clock phases. This block takes those results as a pass mask, where bit n set means phase n sampled correctly. It returns one phase to keep. Passing phases are grouped into windows of adjacent phase numbers. The phase circle is closed, so a window that ends at the top phase continues into a window that starts at phase 0. The block takes the widest window and reports the phase about three quarters of the way into it. The ordering inside the window follows the direction of the scan.

The caller applies a mask together with a one-cycle start pulse. The block keeps its own copy of the mask. It walks the phases one per clock, decides in one closing cycle, and raises a done pulse with the registered result. It uses one clock and an active-low synchronous reset.

Top module: `pw_phase_sel`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `error_o` and `phase_o` read 0 until the first result.
- R2: A mask with no bit set gives `error_o` = 1 on the done pulse. Whenever `error_o` is 1, `phase_o` reads 0.
- R3: Passing phases are scanned from phase 0 upward. Any gap in phase numbers starts a new window. The chosen phase always has its bit set in the captured mask.
- R4: Phase 0 may belong to a window and the top phase (NPH-1) may belong to a different, later window. In that case the two form one window: the top window's phases come first, followed by the phase-0 window's phases. A merged window of NPH or more phases is reported as an error.
- R5: The widest window wins. On equal width the window met first in the scan wins. A merged window ranks at the position of its top-phase part, and the phase-0 part does not compete on its own.
- R6: With window width L, the chosen element is at position k = floor(3L/4), reduced by one when nonzero. Position 0 is the window's first phase, and positions wrap modulo NPH.
- R7: A mask with every bit set is one unmerged window of width 16 and selects phase 11.
- R8: `done_o` is a single-cycle pulse, once for each accepted start. It appears on the 17th rising edge after the edge that samples `start_i`. A `start_i` arriving while a selection is in progress is ignored.
- R9: `phase_o` and `error_o` change only together with a done pulse, and hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Pulse to begin a selection; sampled only when idle |
| mask_i | input | NPH | Pass mask; bit n set means phase n passed |
| done_o | output | 1 | One-cycle pulse marking a new result |
| phase_o | output | $clog2(NPH) | Selected phase, 0 on error |
| error_o | output | 1 | Selection failed (empty mask or oversized merge) |

## Verification
The assertions check on every cycle that done is a one-cycle pulse that always follows a busy period. They also check that an error comes with phase 0, that a mask with no bits gives an error, that the results hold between pulses, and that any chosen phase is one that passed in the captured mask. These properties cannot tell whether the correct passing phase was chosen. The directed scenarios cover that: windows split by gaps, the merge across the top phase, ties broken by scan order, the three-quarter offset for small and full widths, the 17-edge latency, and a start pulse dropped mid-scan. All of them are compared against a list-based reference model.

// File: rtl/pw_sel_pkg.sv
package pw_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pw_offset_calc.sv
// Maps a window (first phase, width) to the phase three quarters in.
module pw_offset_calc #(
    parameter int NPH = 16
) (
    input  logic [$clog2(NPH)-1:0]   win_start_i,
    input  logic [$clog2(NPH+1)-1:0] win_len_i,
    output logic [$clog2(NPH)-1:0]   phase_o
);
    localparam int PW = $clog2(NPH);
    localparam int LW = $clog2(NPH + 1);

    logic [LW+1:0] len3;
    logic [LW+1:0] pos;
    logic [LW+1:0] sum;

    always_comb begin
        len3 = ({2'b00, win_len_i} << 1) + {2'b00, win_len_i};
        pos  = len3 >> 2;
        if (pos != '0) begin
            pos = pos - 1'b1;
        end
        sum = pos + (LW+2)'(win_start_i);
        if (sum >= (LW+2)'(NPH)) begin
            sum = sum - (LW+2)'(NPH);
        end
        phase_o = sum[PW-1:0];
    end
endmodule

// File: rtl/pw_phase_sel.sv
module pw_phase_sel #(
    parameter int NPH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [NPH-1:0]         mask_i,
    output logic                   done_o,
    output logic [$clog2(NPH)-1:0] phase_o,
    output logic                   error_o
);
    import pw_sel_pkg::*;

    localparam int PW = $clog2(NPH);
    localparam int LW = $clog2(NPH + 1);

    typedef struct packed {
        pw_state_e      state;
        logic [PW-1:0]  idx;
        logic [NPH-1:0] mask;
        logic           in_run;
        logic [PW-1:0]  run_start;
        logic [LW-1:0]  run_len;
        logic           have0;
        logic [LW-1:0]  len0;
        logic [PW-1:0]  best_start;
        logic [LW-1:0]  best_len;
        logic           done;
        logic [PW-1:0]  phase;
        logic           err;
    } pw_regs_t;

    pw_regs_t q, d;

    // Closing-cycle decision: last open window, wrap merge, phase-0 window
    logic [PW-1:0] fin_start;
    logic [LW-1:0] fin_len;
    logic          fin_err;
    logic [PW-1:0] fin_phase;
    logic [LW:0]   merged_len;
    logic          h0;

    always_comb begin
        fin_start  = q.best_start;
        fin_len    = q.best_len;
        fin_err    = 1'b0;
        h0         = q.have0;
        merged_len = {1'b0, q.run_len} + {1'b0, q.len0};
        if (q.in_run) begin
            if (q.run_start == '0) begin
                if (q.run_len > fin_len) begin
                    fin_len   = q.run_len;
                    fin_start = '0;
                end
                h0 = 1'b0;
            end else if (q.have0) begin
                if (merged_len >= (LW+1)'(NPH)) begin
                    fin_err = 1'b1;
                end
                if (merged_len > {1'b0, fin_len}) begin
                    fin_len   = merged_len[LW-1:0];
                    fin_start = q.run_start;
                end
                h0 = 1'b0;
            end else if (q.run_len > fin_len) begin
                fin_len   = q.run_len;
                fin_start = q.run_start;
            end
        end
        if (h0 && (q.len0 >= fin_len)) begin
            fin_len   = q.len0;
            fin_start = '0;
        end
        if (fin_len == '0) begin
            fin_err = 1'b1;
        end
    end

    pw_offset_calc #(.NPH(NPH)) u_offset (
        .win_start_i (fin_start),
        .win_len_i   (fin_len),
        .phase_o     (fin_phase)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state    = ST_SCAN;
                    d.idx      = '0;
                    d.mask     = mask_i;
                    d.in_run   = 1'b0;
                    d.run_len  = '0;
                    d.have0    = 1'b0;
                    d.len0     = '0;
                    d.best_len = '0;
                    d.best_start = '0;
                end
            end
            ST_SCAN: begin
                if (q.mask[q.idx]) begin
                    if (q.in_run) begin
                        d.run_len = q.run_len + 1'b1;
                    end else begin
                        d.in_run    = 1'b1;
                        d.run_start = q.idx;
                        d.run_len   = LW'(1);
                    end
                end else if (q.in_run) begin
                    d.in_run = 1'b0;
                    if (q.run_start == '0) begin
                        d.have0 = 1'b1;
                        d.len0  = q.run_len;
                    end else if (q.run_len > q.best_len) begin
                        d.best_len   = q.run_len;
                        d.best_start = q.run_start;
                    end
                end
                if (q.idx == PW'(NPH - 1)) begin
                    d.state = ST_FINISH;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_FINISH: begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
                d.err   = fin_err;
                d.phase = fin_err ? '0 : fin_phase;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    logic [NPH-1:0] held_mask;
    logic           busy;
    assign held_mask = q.mask;
    assign busy      = (q.state != ST_IDLE);

    assign done_o  = q.done;
    assign phase_o = q.phase;
    assign error_o = q.err;
endmodule

// File: rtl/pw_phase_sel_chk.sv
module pw_phase_sel_chk #(
    parameter int NPH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPH-1:0]         held_mask,
    input logic                   busy,
    input logic                   done_o,
    input logic [$clog2(NPH)-1:0] phase_o,
    input logic                   error_o
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    assert_err_phase_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (phase_o == '0));

    assert_empty_is_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (held_mask == '0)) |-> error_o);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(phase_o) && $stable(error_o)));

    assert_pick_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> held_mask[phase_o]);
endmodule

bind pw_phase_sel pw_phase_sel_chk #(.NPH(NPH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .held_mask (held_mask),
    .busy      (busy),
    .done_o    (done_o),
    .phase_o   (phase_o),
    .error_o   (error_o)
);

// File: tb/sim_pw_phase_sel.sv
module sim_pw_phase_sel;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [15:0] mask = '0;
    logic       done;
    logic [3:0] phase;
    logic       err;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pw_phase_sel #(.NPH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask),
        .done_o(done), .phase_o(phase), .error_o(err)
    );

    // Behavioural reference: list of windows, merge, pick, offset
    task automatic ref_pick(input logic [15:0] m, output int ph, output bit e);
        int rs[16];
        int rl[16];
        int nr = 0;
        int prev = -2;
        int best = 0;
        int bi = 0;
        int k;
        for (int p = 0; p < N; p++) begin
            if (m[p]) begin
                if (nr > 0 && prev == p - 1) rl[nr-1]++;
                else begin rs[nr] = p; rl[nr] = 1; nr++; end
                prev = p;
            end
        end
        e = 0; ph = 0;
        if (nr == 0) begin e = 1; return; end
        if (nr > 1 && rs[0] == 0 && rs[nr-1] + rl[nr-1] - 1 == N - 1) begin
            rl[nr-1] += rl[0];
            if (rl[nr-1] >= N) begin e = 1; return; end
            rl[0] = 0;
        end
        for (int r = 0; r < nr; r++) begin
            if (rl[r] > best) begin best = rl[r]; bi = r; end
        end
        k = (best * 3) / 4;
        if (k != 0) k--;
        ph = (rs[bi] + k) % N;
    endtask

    int   m_cnt = 0;
    bit   m_done = 0;
    int   m_phase = 0;
    bit   m_err = 0;
    logic [15:0] m_mask = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_phase = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1;
                    ref_pick(m_mask, m_phase, m_err);
                end
            end else if (start) begin
                m_mask = mask;
                m_cnt = 17;
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            compared++;
            if (done !== m_done) begin
                mismatched++;
                $display("FAIL R8 done actual=%0b expected=%0b", done, m_done);
            end
            if (phase !== 4'(m_phase) || err !== m_err) begin
                mismatched++;
                $display("FAIL R6/R9 phase,err actual=%0d,%0b expected=%0d,%0b",
                         phase, err, m_phase, m_err);
            end
        end
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); start = 1'b1; mask = m;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run(input logic [15:0] m, input bit exp_err, input int exp_ph,
                       input string req);
        int cyc = 0;
        pulse(m);
        while (!done) begin @(negedge clk); cyc++; end
        chk(cyc == 17, "R8 latency", cyc, 17);
        chk(err == exp_err, {req, " error"}, err, exp_err);
        chk(phase == 4'(exp_ph), {req, " phase"}, phase, exp_ph);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && err == 0 && phase == 0, "R1 reset state", {done, err, phase}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 0 && err == 0 && phase == 0, "R1 after release", {done, err, phase}, 0);

        run(16'h0000, 1, 0,  "R2 empty mask");
        run(16'hFFFF, 0, 11, "R7 all pass");
        run(16'h0020, 0, 5,  "R6 single phase");
        run(16'h003C, 0, 4,  "R6 width four");
        run(16'h1F06, 0, 10, "R3 longest of two");
        run(16'hE047, 0, 0,  "R4 wrap merge");
        run(16'h8001, 0, 15, "R4 ends only");
        run(16'hC1E3, 0, 7,  "R5 tie merged later");
        run(16'h0707, 0, 1,  "R5 tie phase0 first");

        // R8: a start during a scan is dropped
        begin
            int cyc = 0;
            pulse(16'h1F06);
            repeat (3) @(negedge clk);
            pulse(16'h0020);
            while (!done) begin @(negedge clk); cyc++; end
            chk(phase == 4'd10, "R8 busy start ignored", phase, 10);
            repeat (25) @(negedge clk);
            chk(done == 0, "R8 no second done", done, 0);
            chk(phase == 4'd10, "R9 result held", phase, 10);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule